// File: doc/BRIEF.md
# Clock-Following Two-Stream Serial Audio Mixer

This block sits between an external audio converter and the rest of the chip. It takes two stereo PCM streams, a line-level stream and a microphone stream, and returns their sum on one serial output lane. The converter is the clock master. It supplies both the bit clock and the left/right frame clock, and this block only samples them. Converter setup, such as sample rate and gain, happens over a separate two-wire control bus and does not pass through here.

Every audio input is brought into the system clock domain through a two-flop synchronizer. Bit-clock edges are detected in that domain. On each rising bit-clock edge the block shifts in one bit from each input lane. Once both channels of a frame have been captured, it adds the line and microphone samples channel by channel and clips the sum to the 16-bit range. It then shifts the mixed pair out during the next frame, changing the output only after falling bit-clock edges.

The framing is the standard one-bit-delayed stereo format at a nominal 48 kHz frame rate. Each half-frame must carry at least 17 bit clocks. Each bit-clock phase must last at least three system clocks.

Top module: `serial_audio_mixer`

## Requirements
- R1: From reset the output lane is 0. It stays 0 until one left half followed by one right half has been fully captured after reset.
- R2: Input framing follows these rules.
  - A frame clock low marks the left channel and a frame clock high marks the right channel.
  - Each sample is 16-bit two's complement, sent MSB first.
  - The MSB is taken on the second rising bit-clock edge after a frame-clock change, which gives a one-bit delay.
  - All input bits are taken on rising edges.
- R3: Input bits outside the 16 sample bits of a half-frame are ignored. This covers the delay bit and any padding after the LSB.
- R4: When the sum of the line sample and the microphone sample of the same channel lies in [-32768, +32767], the mixed value is that exact sum.
- R5: A sum above +32767 is output as 0x7FFF.
- R6: A sum below -32768 is output as 0x8000.
- R7: The output lane follows these rules.
  - The mixed left and right samples of frame k are sent in the left and right halves of frame k+1.
  - Each is sent MSB first, with the MSB on the second falling bit-clock edge after the frame-clock change.
  - The delay bit and every bit after the LSB are driven 0.
- R8: The output lane changes only in response to a falling bit-clock edge. It stays stable while the bit clock is high.
- R9: The left and right channels are mixed independently. No sample from one channel reaches the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bclk_i | input | 1 | Bit clock from the converter |
| lrclk_i | input | 1 | Left/right frame clock from the converter (low = left) |
| line_sd_i | input | 1 | Line-level serial data input |
| mic_sd_i | input | 1 | Microphone serial data input |
| mix_sd_o | output | 1 | Mixed serial data output |

## Verification
A falling bit-clock edge reaches the output about three system clocks later, after two synchronizer stages, one edge register and the output register. The bench therefore reads each output bit at the following rising bit-clock edge, eight system clocks after that falling edge. At that point the bit is settled and no later edge has yet been seen. It then watches the lane through the whole high phase to confirm that nothing moves there.

Mixed samples are due one whole frame after their inputs. The bench compares the word collected in frame k+1 against the clipped sum it computed for frame k. The first frame after each reset must come back as zero. All stimulus edges are placed on falling system-clock edges, away from the edges the design samples on.

// File: rtl/sam_pkg.sv
// Package: shared constants and types of the serial audio mixer.
// Assumes nothing; only widths and the channel encoding live here.
package sam_pkg;
    localparam int SAMPLE_W    = 16;  // bits per audio sample
    localparam int SYNC_STAGES = 2;   // flops per synchronizer
    localparam int N_LANES     = 2;   // line lane and microphone lane

    // Frame-clock level that marks each channel.
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;
endpackage

// File: rtl/sam_sync.sv
// Module: multi-bit level synchronizer.
// Each bit of async_i passes through STAGES flops into the clk domain.
// Assumes the bits are unrelated or change slowly relative to clk, and STAGES >= 2.
module sam_sync #(
    parameter int W      = 4,
    parameter int STAGES = sam_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o
);
    logic [STAGES-1:0][W-1:0] stage_q;

    // Shift the sampled inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign level_o = stage_q[STAGES-1];
endmodule

// File: rtl/sam_rx.sv
// Module: one-lane serial sample receiver.
// On each rising bit-clock pulse it shifts in one bit. A change of the frame
// clock arms the counter, so the next W bits form the sample, MSB first.
// Later bits are ignored. After reset it stays idle until a frame-clock change.
// Assumes at least W+1 bit clocks per half-frame and W >= 3.
module sam_rx #(
    parameter int W = sam_pkg::SAMPLE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_rise_i,
    input  logic         lr_i,
    input  logic         sd_i,
    output logic [W-1:0] word_o,
    output logic         done_o
);
    localparam int            CW    = $clog2(W + 1);
    localparam logic [CW-1:0] IDLE  = CW'(W);
    localparam logic [CW-1:0] LAST  = CW'(W - 1);

    logic [CW-1:0] cnt_q;
    logic [W-2:0]  shift_q;
    logic          lr_prev_q;

    // Track framing and assemble one sample per half-frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= IDLE;
            shift_q   <= '0;
            lr_prev_q <= 1'b0;
            word_o    <= '0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (bit_rise_i) begin
                lr_prev_q <= lr_i;
                if (lr_i != lr_prev_q) begin
                    cnt_q <= '0;
                end else if (cnt_q != IDLE) begin
                    shift_q <= {shift_q[W-3:0], sd_i};
                    cnt_q   <= cnt_q + 1'b1;
                    if (cnt_q == LAST) begin
                        word_o <= {shift_q, sd_i};
                        done_o <= 1'b1;
                    end
                end
            end
        end
    end

    // R2: a completed sample is announced for a single cycle only.
    a_r2_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/sam_sat.sv
// Module: saturating two's-complement adder.
// Adds a and b. A result outside the W-bit range clips to the nearest end.
// Purely combinational; assumes both operands are W-bit two's complement.
module sam_sat #(
    parameter int W = sam_pkg::SAMPLE_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] sum;

    // Widen by one bit, add, then clip on overflow.
    always_comb begin
        sum = {a_i[W-1], a_i} + {b_i[W-1], b_i};
        if (sum[W] != sum[W-1]) begin
            y_o = sum[W] ? NEG_MIN : POS_MAX;
        end else begin
            y_o = sum[W-1:0];
        end
    end
endmodule

// File: rtl/sam_tx.sv
// Module: serial sample transmitter.
// On a falling bit-clock pulse with a changed frame clock, it loads the
// channel's word and drives a 0 delay bit. It then sends W bits MSB first,
// then zeros. The output register moves only on falling bit-clock pulses.
// Assumes at least W+1 bit clocks per half-frame.
module sam_tx #(
    parameter int W = sam_pkg::SAMPLE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_fall_i,
    input  logic         lr_i,
    input  logic [W-1:0] word_l_i,
    input  logic [W-1:0] word_r_i,
    output logic         sd_o
);
    import sam_pkg::*;

    localparam int            CW   = $clog2(W + 1);
    localparam logic [CW-1:0] IDLE = CW'(W);

    logic [CW-1:0] cnt_q;
    logic [W-1:0]  shift_q;
    logic          lr_prev_q;

    // Load at each half-frame start and shift one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= IDLE;
            shift_q   <= '0;
            lr_prev_q <= 1'b0;
            sd_o      <= 1'b0;
        end else if (bit_fall_i) begin
            lr_prev_q <= lr_i;
            if (lr_i != lr_prev_q) begin
                shift_q <= (chan_e'(lr_i) == CH_RIGHT) ? word_r_i : word_l_i;
                cnt_q   <= '0;
                sd_o    <= 1'b0;
            end else if (cnt_q != IDLE) begin
                sd_o    <= shift_q[W-1];
                shift_q <= shift_q << 1;
                cnt_q   <= cnt_q + 1'b1;
            end else begin
                sd_o    <= 1'b0;
            end
        end
    end

    // R8: the serial output moves only right after a falling bit-clock pulse.
    a_r8_change_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd_o) |-> $past(bit_fall_i));
endmodule

// File: rtl/serial_audio_mixer.sv
// Module: clock-following two-stream serial audio mixer (top).
// It synchronizes the converter's bit clock, frame clock and two data lanes,
// detects bit-clock edges, and captures line and microphone samples per
// channel. It mixes them with saturation once a left+right frame is complete
// and sends the mix out during the following frame.
// Assumes at least 17 bit clocks per half-frame and bit-clock phases of at
// least three clk periods.
module serial_audio_mixer #(
    parameter int SAMPLE_W    = sam_pkg::SAMPLE_W,
    parameter int SYNC_STAGES = sam_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic lrclk_i,
    input  logic line_sd_i,
    input  logic mic_sd_i,
    output logic mix_sd_o
);
    import sam_pkg::*;

    localparam int NL  = N_LANES;
    localparam int NCH = 2;
    localparam int SW  = NL + 2;

    logic [SW-1:0]       sync_lvl;
    logic                bclk_lvl, lr_lvl, bclk_prev_q;
    logic                bit_rise, bit_fall;
    logic [NL-1:0]       lane_sd;
    logic [SAMPLE_W-1:0] rx_word   [NL];
    logic [NL-1:0]       rx_done;
    logic [SAMPLE_W-1:0] left_hold [NL];
    logic [SAMPLE_W-1:0] sat_a [NCH];
    logic [SAMPLE_W-1:0] sat_b [NCH];
    logic [SAMPLE_W-1:0] sat_y [NCH];
    logic [SAMPLE_W-1:0] mix_l_q, mix_r_q;
    logic                left_ok_q, mix_ok_q, frame_done;

    sam_sync #(.W(SW), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({mic_sd_i, line_sd_i, lrclk_i, bclk_i}),
        .level_o (sync_lvl)
    );

    assign bclk_lvl = sync_lvl[0];
    assign lr_lvl   = sync_lvl[1];
    assign lane_sd  = sync_lvl[SW-1:2];

    // Remember the previous bit-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_prev_q <= 1'b0;
        else        bclk_prev_q <= bclk_lvl;
    end

    assign bit_rise = bclk_lvl & ~bclk_prev_q;
    assign bit_fall = ~bclk_lvl & bclk_prev_q;

    // One receiver per input lane: lane 0 is line, lane 1 is microphone.
    for (genvar g = 0; g < NL; g++) begin : g_lane
        sam_rx #(.W(SAMPLE_W)) rx_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .bit_rise_i (bit_rise),
            .lr_i       (lr_lvl),
            .sd_i       (lane_sd[g]),
            .word_o     (rx_word[g]),
            .done_o     (rx_done[g])
        );
    end

    assign frame_done = &rx_done;

    // One saturating adder per channel: left from held words, right live.
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        if (c == 0) begin : g_left
            assign sat_a[c] = left_hold[0];
            assign sat_b[c] = left_hold[1];
        end else begin : g_right
            assign sat_a[c] = rx_word[0];
            assign sat_b[c] = rx_word[1];
        end

        sam_sat #(.W(SAMPLE_W)) sat_i (
            .a_i (sat_a[c]),
            .b_i (sat_b[c]),
            .y_o (sat_y[c])
        );

        // R5: two non-negative operands never wrap to a smaller value.
        a_r5_no_pos_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (!sat_a[c][SAMPLE_W-1] && !sat_b[c][SAMPLE_W-1]) |->
            ($signed(sat_y[c]) >= $signed(sat_a[c]) &&
             $signed(sat_y[c]) >= $signed(sat_b[c])));

        // R6: two negative operands never wrap to a larger value.
        a_r6_no_neg_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (sat_a[c][SAMPLE_W-1] && sat_b[c][SAMPLE_W-1]) |->
            ($signed(sat_y[c]) <= $signed(sat_a[c]) &&
             $signed(sat_y[c]) <= $signed(sat_b[c])));
    end

    // Hold left words, and latch the mixed pair when the right half completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NL; i++) left_hold[i] <= '0;
            left_ok_q <= 1'b0;
            mix_ok_q  <= 1'b0;
            mix_l_q   <= '0;
            mix_r_q   <= '0;
        end else if (frame_done) begin
            if (chan_e'(lr_lvl) == CH_LEFT) begin
                for (int i = 0; i < NL; i++) left_hold[i] <= rx_word[i];
                left_ok_q <= 1'b1;
            end else if (left_ok_q) begin
                mix_l_q  <= sat_y[0];
                mix_r_q  <= sat_y[1];
                mix_ok_q <= 1'b1;
            end
        end
    end

    sam_tx #(.W(SAMPLE_W)) tx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_fall_i (bit_fall),
        .lr_i       (lr_lvl),
        .word_l_i   (mix_l_q),
        .word_r_i   (mix_r_q),
        .sd_o       (mix_sd_o)
    );

    // R2: both lanes finish their samples in the same cycle.
    a_r2_lanes_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done[0] == rx_done[1]);

    // R1: no mixed frame yet means a silent output lane.
    a_r1_silent_until_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !mix_ok_q |-> !mix_sd_o);
endmodule

// File: tb/serial_audio_mixer_tb_top.sv
// Bench: acts as the converter. It drives the bit clock, frame clock and both
// lanes, decodes the output lane and compares it with sums computed here.
module serial_audio_mixer_tb_top;
    localparam int HALF_T    = 8;   // clk periods per bit-clock phase
    localparam int HALF_BITS = 32;  // bit clocks per half-frame
    localparam int NV        = 8;

    // Each row: {line_left, line_right, mic_left, mic_right}.
    localparam logic [63:0] VEC [NV] = '{
        {16'h0001, 16'h0003, 16'h0002, 16'h0004},
        {16'h7000, 16'h8000, 16'h2000, 16'hFFFF},
        {16'h7FFF, 16'h8000, 16'h0000, 16'h0000},
        {16'h4000, 16'hC000, 16'h3FFF, 16'hC000},
        {16'h1234, 16'hFFFF, 16'hFFFF, 16'hFFFF},
        {16'h7FFF, 16'h8000, 16'h7FFF, 16'h8000},
        {16'hA5A5, 16'h5A5A, 16'h0F0F, 16'h1111},
        {16'h4000, 16'hBFFF, 16'h4000, 16'hC000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0;
    logic lrclk = 1'b1;
    logic sd_line = 1'b0;
    logic sd_mic = 1'b0;
    logic sd_out;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    serial_audio_mixer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_i    (bclk),
        .lrclk_i   (lrclk),
        .line_sd_i (sd_line),
        .mic_sd_i  (sd_mic),
        .mix_sd_o  (sd_out)
    );

    function automatic logic [15:0] mix_ref(input logic [15:0] a, input logic [15:0] b);
        int sa, sb, s;
        sa = $signed(a);
        sb = $signed(b);
        s  = sa + sb;
        if (s > 32767)  s = 32767;
        if (s < -32768) s = -32768;
        return s[15:0];
    endfunction

    function automatic string vec_tag(input int i);
        case (i)
            0:       return "R4 R9";
            3, 4, 6: return "R4";
            default: return "R5 R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // One half-frame: drive the lanes and decode and watch the output lane.
    task automatic drive_half(input logic lr, input logic [15:0] wl, input logic [15:0] wm,
                              output logic [15:0] got, output int padbad, output int unstable);
        logic s;
        got = '0;
        padbad = 0;
        unstable = 0;
        for (int b = 0; b < HALF_BITS; b++) begin
            bclk = 1'b0;
            if (b == 0) lrclk = lr;
            if (b >= 1 && b <= 16) begin
                sd_line = wl[16-b];
                sd_mic  = wm[16-b];
            end else begin
                sd_line = 1'b1;   // R3: padding and delay bits carry junk
                sd_mic  = 1'b1;
            end
            repeat (HALF_T) @(negedge clk);
            bclk = 1'b1;
            s = sd_out;
            if (b >= 1 && b <= 16) got[16-b] = s;
            else if (s !== 1'b0) padbad++;
            repeat (HALF_T) begin
                @(negedge clk);
                if (sd_out !== s) unstable++;
            end
        end
    endtask

    task automatic run_frame(input logic [63:0] v, input logic [15:0] el, input logic [15:0] er,
                             input string tag);
        logic [15:0] gl, gr;
        int pl, pr, ul, ur;
        drive_half(1'b0, v[63:48], v[31:16], gl, pl, ul);
        drive_half(1'b1, v[47:32], v[15:0],  gr, pr, ur);
        check({tag, " R2 R3 R7 left"},  gl, el);
        check({tag, " R2 R3 R7 right"}, gr, er);
        check("R7 padding bits zero", 16'(pl + pr), 16'd0);
        check("R8 stable while bit clock high", 16'(ul + ur), 16'd0);
    endtask

    task automatic preroll();
        logic [15:0] g;
        int p, u;
        drive_half(1'b1, 16'hFFFF, 16'hFFFF, g, p, u);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] el, er;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R1 output after reset", {15'd0, sd_out}, 16'd0);

        // An incomplete right half first: it must not count as a frame (R1).
        preroll();

        el = 16'h0000;
        er = 16'h0000;
        for (int f = 0; f <= NV; f++) begin
            logic [63:0] v;
            v = (f < NV) ? VEC[f] : 64'd0;
            run_frame(v, el, er, (f == 0) ? "R1 first frame silent" : vec_tag(f - 1));
            el = mix_ref(v[63:48], v[31:16]);
            er = mix_ref(v[47:32], v[15:0]);
        end

        // Directed: reset mid-stream, then a frame must be silent and its
        // mix must appear one frame later (R1, R4, R7).
        bclk = 1'b0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R1 output after second reset", {15'd0, sd_out}, 16'd0);
        preroll();
        run_frame({16'h0100, 16'h0200, 16'h0010, 16'h0020}, 16'h0000, 16'h0000,
                  "R1 silent after reset");
        run_frame(64'd0, 16'h0110, 16'h0220, "R4 one frame latency");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule